// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one load/store-multiple request into a stream of single-word memory accesses. A request carries a register selection mask, a base address and three mode bits. The mode bits choose whether the base is applied before or after each step, whether the block grows upward or downward from the base, and whether the adjusted base is written back. The sequencer emits one access for each selected register. Each access gives the register index and the word address. The access is accepted on any cycle in which the memory ready input is high.

Registers always go out in ascending index order to ascending word addresses, whatever the direction bit says. For downward blocks the sequencer first works out how many registers are selected. It then starts at the bottom of the block, so the lowest-numbered register still meets the lowest address. When the last access has been accepted, the block raises a one-cycle completion pulse. With that pulse it presents the updated base and a write-back strobe. The four stack conventions (full or empty, ascending or descending) are expressed through the before/after bit and the up/down bit.

Top module: `blkx_seq`

## Requirements
- R1: Bit i of `reg_list_i` selects register i. Exactly one access is issued per set bit, with `acc_idx_o` taking the selected indices in strictly ascending order.
- R2: Successive accepted accesses go to addresses that rise by 4 bytes, so the lowest selected register always uses the lowest address. Example: base 0x1000, list 0x00A2, upward, after-step, write-back gives 0x1000, 0x1004, 0x1008 and a final base of 0x100C.
- R3: For upward requests (`up_i`=1), the first address is the base when `pre_i`=0 (increment-after) and base+4 when `pre_i`=1 (increment-before).
- R4: For downward requests (`up_i`=0) with n selected registers, the first address is base-4n when `pre_i`=1 (decrement-before) and base-4n+4 when `pre_i`=0 (decrement-after). Arithmetic wraps modulo 2^32.
- R5: While `done_o` is high, `new_base_o` equals base+4n (upward) or base-4n (downward) when `wb_i` was set at start, and equals the unmodified base when `wb_i` was clear. `base_we_o` equals the start-time `wb_i` and is high only together with `done_o`.
- R6: An empty list issues no access. `done_o` is high in the cycle right after the start was accepted, with `new_base_o` equal to the base.
- R7: While `acc_valid_o` is high and `mem_rdy_i` is low, the access is held: index and address stay unchanged and the sequence does not advance.
- R8: `done_o` is a single-cycle pulse in the cycle after the last access is accepted, and `acc_valid_o` is low while it is high. A `start_i` that arrives while `busy_o` is high is ignored.
- R9: After reset, `busy_o`, `acc_valid_o`, `done_o` and `base_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only when idle |
| reg_list_i | input | 16 | Register selection mask, bit i = register i |
| base_i | input | 32 | Base byte address |
| pre_i | input | 1 | 1 = step before use, 0 = step after use |
| up_i | input | 1 | 1 = block above base, 0 = block below base |
| wb_i | input | 1 | 1 = write the adjusted base back |
| mem_rdy_i | input | 1 | Memory accepts the current access |
| busy_o | output | 1 | A request is in progress |
| acc_valid_o | output | 1 | An access is being presented |
| acc_idx_o | output | 4 | Register index of the current access |
| acc_addr_o | output | 32 | Word address of the current access |
| done_o | output | 1 | One-cycle completion pulse |
| new_base_o | output | 32 | Base value to store, valid with done_o |
| base_we_o | output | 1 | Base write-back strobe, valid with done_o |

## Verification
A request sampled at a clock edge shows its first access, or its completion pulse for an empty list, in the cycle right after that edge. Each access accepted at an edge is replaced by the next access, or by `done_o`, at that same edge. The bench drives its inputs and reads the outputs at the falling edge. So each value it reads is the state left by the rising edge just before, and the ready level it drives there takes effect at the next rising edge. For every access it compares index and address against a model that scans the mask in arithmetic. It counts accepted accesses to predict the exact cycle of `done_o`. It also checks the base value and strobe within that single pulse.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } seq_state_t;

   // clears the lowest set bit of a mask
   function automatic logic [63:0] drop_lowest(input logic [63:0] v);
      return v & (v - 64'd1);
   endfunction

endpackage

// File: rtl/blkx_popcount.sv
module blkx_popcount #(
   parameter int W  = 16,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] count_o
);
   logic [CW-1:0] partial [0:W];

   assign partial[0] = '0;
   for (genvar g = 0; g < W; g++) begin : g_sum
      assign partial[g+1] = partial[g] + CW'(vec_i[g]);
   end
   assign count_o = partial[W];
endmodule

// File: rtl/blkx_lowest_set.sv
module blkx_lowest_set #(
   parameter int W      = 16,
   parameter int IW     = (W > 1) ? $clog2(W) : 1,
   parameter int ISOLATE = 1
) (
   input  logic [W-1:0]  vec_i,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);
   assign any_o = |vec_i;

   if (ISOLATE != 0) begin : g_isolate
      logic [W-1:0] one_hot;
      assign one_hot = vec_i & (~vec_i + W'(1));
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < W; i++) begin
            if (one_hot[i]) idx_o = idx_o | IW'(i);
         end
      end
   end else begin : g_scan
      always_comb begin
         idx_o = '0;
         for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
         end
      end
   end
endmodule

// File: rtl/blkx_addr_gen.sv
module blkx_addr_gen #(
   parameter int AW      = 32,
   parameter int CW      = 5,
   parameter int STEP_SH = 2
) (
   input  logic [AW-1:0] base_i,
   input  logic [CW-1:0] count_i,
   input  logic          pre_i,
   input  logic          up_i,
   output logic [AW-1:0] first_o,
   output logic [AW-1:0] final_o
);
   localparam logic [AW-1:0] STEP = AW'(1) << STEP_SH;

   logic [AW-1:0] span;
   assign span = AW'(count_i) << STEP_SH;

   always_comb begin
      if (up_i) begin
         final_o = base_i + span;
         first_o = pre_i ? base_i + STEP : base_i;
      end else begin
         final_o = base_i - span;
         first_o = pre_i ? final_o : final_o + STEP;
      end
   end
endmodule

// File: rtl/blkx_seq.sv
module blkx_seq #(
   parameter int NUM_REGS   = 16,
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   parameter int FIND_ISOLATE = 1,
   localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int CNT_W   = $clog2(NUM_REGS + 1),
   localparam int STEP_SH = $clog2(WORD_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [NUM_REGS-1:0] reg_list_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              pre_i,
   input  logic              up_i,
   input  logic              wb_i,
   input  logic              mem_rdy_i,
   output logic              busy_o,
   output logic              acc_valid_o,
   output logic [IDX_W-1:0]  acc_idx_o,
   output logic [ADDR_W-1:0] acc_addr_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] new_base_o,
   output logic              base_we_o
);
   import blkx_pkg::*;

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   if (NUM_REGS < 1 || NUM_REGS > 64) begin : g_chk_regs
      $error("NUM_REGS must lie in 1..64");
   end
   if ((1 << STEP_SH) != WORD_BYTES) begin : g_chk_word
      $error("WORD_BYTES must be a power of two");
   end
   if (ADDR_W <= STEP_SH + CNT_W) begin : g_chk_addr
      $error("ADDR_W too narrow for the block span");
   end

   seq_state_t          state_q;
   logic [NUM_REGS-1:0] pend_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [ADDR_W-1:0]   fin_q;
   logic                wb_q;

   logic [CNT_W-1:0]    sel_count;
   logic [ADDR_W-1:0]   first_addr;
   logic [ADDR_W-1:0]   final_base;
   logic [IDX_W-1:0]    cur_idx;
   logic                pend_any;
   logic [NUM_REGS-1:0] pend_next;

   blkx_popcount #(.W(NUM_REGS), .CW(CNT_W)) u_count (
      .vec_i   (reg_list_i),
      .count_o (sel_count)
   );

   blkx_addr_gen #(.AW(ADDR_W), .CW(CNT_W), .STEP_SH(STEP_SH)) u_addr (
      .base_i  (base_i),
      .count_i (sel_count),
      .pre_i   (pre_i),
      .up_i    (up_i),
      .first_o (first_addr),
      .final_o (final_base)
   );

   blkx_lowest_set #(.W(NUM_REGS), .IW(IDX_W), .ISOLATE(FIND_ISOLATE)) u_find (
      .vec_i (pend_q),
      .idx_o (cur_idx),
      .any_o (pend_any)
   );

   assign pend_next = NUM_REGS'(drop_lowest(64'(pend_q)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= '0;
         addr_q  <= '0;
         fin_q   <= '0;
         wb_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  pend_q  <= reg_list_i;
                  addr_q  <= first_addr;
                  fin_q   <= wb_i ? final_base : base_i;
                  wb_q    <= wb_i;
                  state_q <= (|reg_list_i) ? ST_RUN : ST_DONE;
               end
            end
            ST_RUN: begin
               if (mem_rdy_i) begin
                  pend_q <= pend_next;
                  addr_q <= addr_q + STEP;
                  if (pend_next == '0) state_q <= ST_DONE;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign acc_valid_o = (state_q == ST_RUN) && pend_any;
   assign acc_idx_o   = cur_idx;
   assign acc_addr_o  = addr_q;
   assign done_o      = (state_q == ST_DONE);
   assign new_base_o  = fin_q;
   assign base_we_o   = done_o && wb_q;
endmodule

// File: rtl/blkx_seq_chk.sv
module blkx_seq_chk #(
   parameter int IDX_W  = 4,
   parameter int ADDR_W = 32,
   parameter int WORD_BYTES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              mem_rdy_i,
   input logic              busy_o,
   input logic              acc_valid_o,
   input logic [IDX_W-1:0]  acc_idx_o,
   input logic [ADDR_W-1:0] acc_addr_o,
   input logic              done_o,
   input logic              base_we_o
);
   assert_idx_ascend_R1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid_o && mem_rdy_i |=> !acc_valid_o || (acc_idx_o > $past(acc_idx_o)));

   assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid_o && mem_rdy_i |=> !acc_valid_o ||
         (acc_addr_o == $past(acc_addr_o) + ADDR_W'(WORD_BYTES)));

   assert_we_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      base_we_o |-> done_o);

   assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid_o && !mem_rdy_i |=> acc_valid_o && $stable(acc_addr_o) && $stable(acc_idx_o));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !acc_valid_o);

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !acc_valid_o && !done_o);
endmodule

bind blkx_seq blkx_seq_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .mem_rdy_i   (mem_rdy_i),
   .busy_o      (busy_o),
   .acc_valid_o (acc_valid_o),
   .acc_idx_o   (acc_idx_o),
   .acc_addr_o  (acc_addr_o),
   .done_o      (done_o),
   .base_we_o   (base_we_o)
);

// File: tb/blkx_seq_tb.sv
`timescale 1ns/1ps
module blkx_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] reg_list_i = '0;
   logic [31:0] base_i = '0;
   logic        pre_i = 1'b0, up_i = 1'b0, wb_i = 1'b0;
   logic        mem_rdy_i = 1'b0;
   logic        busy_o, acc_valid_o, done_o, base_we_o;
   logic [3:0]  acc_idx_o;
   logic [31:0] acc_addr_o, new_base_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   blkx_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .reg_list_i(reg_list_i),
      .base_i(base_i), .pre_i(pre_i), .up_i(up_i), .wb_i(wb_i),
      .mem_rdy_i(mem_rdy_i), .busy_o(busy_o), .acc_valid_o(acc_valid_o),
      .acc_idx_o(acc_idx_o), .acc_addr_o(acc_addr_o), .done_o(done_o),
      .new_base_o(new_base_o), .base_we_o(base_we_o)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] step_lfsr(input logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   // rdy_mode: 0 always ready, 1 pseudo-random ready
   task automatic run_req(input logic [15:0] list, input logic [31:0] base,
                          input bit pre, input bit up, input bit wb,
                          input int rdy_mode, input bit poke);
      int n = 0;
      int k = 0;
      int guard = 0;
      logic [15:0] pend = list;
      logic [31:0] first, fin;
      for (int i = 0; i < 16; i++) n += int'(list[i]);
      if (up) begin
         fin = base + 32'(4 * n);
         first = pre ? base + 32'd4 : base;
      end else begin
         fin = base - 32'(4 * n);
         first = pre ? fin : fin + 32'd4;
      end
      @(negedge clk);
      start_i = 1'b1; reg_list_i = list; base_i = base;
      pre_i = pre; up_i = up; wb_i = wb; mem_rdy_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      reg_list_i = ~list; base_i = ~base;
      while (!done_o && guard < 400) begin
         int exp_idx = 0;
         for (int i = 15; i >= 0; i--) if (pend[i]) exp_idx = i;
         check(acc_valid_o === 1'b1 && k < n, "R1 access presented", 32'(acc_valid_o), 32'd1);
         check(acc_idx_o === 4'(exp_idx), "R1 register index", 32'(acc_idx_o), 32'(exp_idx));
         check(acc_addr_o === first + 32'(4 * k),
               up ? "R3/R2 address" : "R4/R2 address", acc_addr_o, first + 32'(4 * k));
         if (poke && k == 0 && n >= 2) begin
            start_i = 1'b1; reg_list_i = 16'h0001; base_i = 32'h0;
         end else begin
            start_i = 1'b0;
         end
         lfsr = step_lfsr(lfsr);
         mem_rdy_i = (rdy_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
         if (mem_rdy_i) begin
            k++;
            pend = pend & (pend - 16'd1);
         end
         @(negedge clk);
         start_i = 1'b0;
         if (rdy_mode != 0 && !mem_rdy_i && !done_o)
            check(acc_addr_o === first + 32'(4 * k), "R7 stall hold", acc_addr_o,
                  first + 32'(4 * k));
         guard++;
      end
      mem_rdy_i = 1'b0;
      check(done_o === 1'b1, "R8 done seen", 32'(done_o), 32'd1);
      check(k == n, n == 0 ? "R6 no access on empty list" : "R8 done after last access",
            32'(k), 32'(n));
      check(acc_valid_o === 1'b0, "R8 no access with done", 32'(acc_valid_o), 32'd0);
      check(new_base_o === (wb ? fin : base), n == 0 ? "R6 base unchanged" : "R5 new base",
            new_base_o, wb ? fin : base);
      check(base_we_o === wb, "R5 write-back strobe", 32'(base_we_o), 32'(wb));
      @(negedge clk);
      check(done_o === 1'b0 && busy_o === 1'b0, "R8 single-cycle done", 32'(done_o), 32'd0);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] lists [0:39];
      logic [31:0] bases [0:2];
      bases[0] = 32'h0000_1000; bases[1] = 32'h0000_0008; bases[2] = 32'hFFFF_FFF0;
      lists[0] = 16'h0000; lists[1] = 16'hFFFF; lists[2] = 16'h00A2; lists[3] = 16'h8001;
      for (int i = 0; i < 16; i++) lists[4 + i] = 16'h1 << i;
      for (int i = 20; i < 40; i++) begin
         lfsr = step_lfsr(step_lfsr(lfsr));
         lists[i] = lfsr ^ 16'(i * 16'h1357);
      end
      repeat (3) @(negedge clk);
      check(busy_o === 1'b0 && acc_valid_o === 1'b0 && done_o === 1'b0 && base_we_o === 1'b0,
            "R9 reset state", {busy_o, acc_valid_o, done_o, base_we_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy_o === 1'b0, "R9 idle after reset", 32'(busy_o), 32'd0);
      // worked example: regs 1,5,7 upward after-step with write-back (R2)
      run_req(16'h00A2, 32'h0000_1000, 1'b0, 1'b1, 1'b1, 0, 1'b0);
      for (int m = 0; m < 8; m++) begin
         for (int l = 0; l < 40; l++) begin
            for (int b = 0; b < 3; b++) begin
               run_req(lists[l], bases[b], m[0], m[1], m[2], (l + b) % 2, (l % 5) == 1);
            end
         end
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule